// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Flag

This unit performs the four shift/rotate families on a register operand of byte, word or long size, in either direction. The families are arithmetic shift, logical shift, rotate through the extend flag, and plain rotate. It takes a 16-bit operation word, the operand, the value of the register that may supply the count, and the incoming extend flag. From these it produces three things: the result with untouched upper register bits, the five condition flags (negative, zero, overflow, carry, extend), and the cycle cost of the operation. It also accepts the single-position memory form, which always works on a word. Fetching the operand and writing it back belong to the surrounding pipeline.

An operation enters through a valid/ready handshake and is computed in a single cycle. The result is held in one output register that is drained by its own valid/ready handshake. The input is ready whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds still and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. The cycle-count output reports cost only and never stalls the unit.

Top module: `shr_unit`

## Requirements
- R1: Register form: bits 11:9 give the count or count register, bit 8 gives the direction (1 = left), bits 7:6 give the size (00 byte, 01 word, 10 long), bit 5 set means the count comes from the register, and bits 4:3 give the kind (0 arithmetic shift, 1 logical shift, 2 rotate through extend, 3 plain rotate).
- R2: An immediate count field of 000 means 8. A register-supplied count is the low 6 bits of `in_count_reg` (0 to 63).
- R3: Bits 7:6 = 11 select the memory form: word size, count 1, kind in bits 10:9, direction in bit 8.
- R4: Arithmetic and logical shifts with a nonzero count set carry and extend to the last bit shifted out. With a zero count, carry is 0 and extend keeps `in_x`. Overflow is 0 except on a left arithmetic shift.
- R5: A left arithmetic shift sets overflow when the sign bit would change at any step. This includes counts at or beyond the width whenever the operand is nonzero.
- R6: Rotate through extend rotates over width+1 bits, with extend as the extra bit, and its count is taken modulo width+1. Carry and extend take the last bit rotated out. A count that reduces to 0 leaves the value unchanged and sets carry = extend = `in_x`. Overflow is 0.
- R7: Plain rotate clears overflow and keeps extend. Carry is the last bit rotated around (result MSB for right, LSB for left). A zero count clears carry.
- R8: Negative and zero come from the result at the operand size. Register bits above the size are passed through from `in_operand`.
- R9: `out_cycles` = 6 (byte, word) or 8 (long) plus 2 per count. The memory form costs 8.
- R10: `in_ready` = !out_valid || out_ready. An accepted operation appears at the outputs on the next cycle. A stalled output holds all its values.
- R11: While reset is asserted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_opcode | input | 16 | Operation word |
| in_operand | input | 32 | Register or memory operand |
| in_count_reg | input | 32 | Value of the count register |
| in_x | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result, upper bits preserved |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_x | output | 1 | Extend flag |
| out_cycles | output | 8 | Cycle cost of the operation |

## Verification
Two events can share one clock edge: draining the held result and accepting a new operation. The bench provokes this by stalling the output with a first result held, offering a second operation, and then raising `out_ready`. It judges the outcome on three points. The first result stays stable through the stall. The second operation is not taken early. The register then swaps directly to the second result without an empty cycle.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int CYC_W  = 8;
  localparam int OP_W   = 16;
  localparam int WIDE   = 2 * DATA_W;
  localparam int XW     = 4 * DATA_W;
  localparam int IW     = $clog2(XW);

  typedef enum logic [1:0] {
    K_ASH = 2'd0,
    K_LSH = 2'd1,
    K_ROX = 2'd2,
    K_ROT = 2'd3
  } shr_kind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef struct packed {
    shr_kind_e             kind;
    logic                  left;
    logic [1:0]            size;
    logic [CNT_W-1:0]      count;
    logic                  mem_form;
  } shr_ctl_t;
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [CNT_W-1:0] count_src,
  output shr_ctl_t         ctl,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [CYC_W-1:0] BASE_SHORT = CYC_W'(6);
  localparam logic [CYC_W-1:0] BASE_LONG  = CYC_W'(8);

  logic unused_bits;
  assign unused_bits = ^{opcode[15:12], opcode[2:0]};

  always_comb begin
    ctl.mem_form = (opcode[7:6] == 2'b11);
    ctl.left     = opcode[8];
    if (ctl.mem_form) begin
      ctl.kind  = shr_kind_e'(opcode[10:9]);
      ctl.size  = SZ_WORD;
      ctl.count = CNT_W'(1);
    end else begin
      ctl.kind = shr_kind_e'(opcode[4:3]);
      ctl.size = opcode[7:6];
      if (opcode[5])
        ctl.count = count_src;
      else if (opcode[11:9] == 3'd0)
        ctl.count = CNT_W'(8);
      else
        ctl.count = CNT_W'(opcode[11:9]);
    end
    cycles = ((ctl.size == SZ_LONG) ? BASE_LONG : BASE_SHORT)
           + CYC_W'({ctl.count, 1'b0});
  end
endmodule

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
(
  input  shr_ctl_t          ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic              x_in,
  output logic [DATA_W-1:0] result,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              x_o
);
  localparam logic [IW-1:0] W_B  = IW'(8);
  localparam logic [IW-1:0] W_W  = IW'(16);
  localparam logic [IW-1:0] W_L  = IW'(DATA_W);
  localparam logic [IW-1:0] M_B  = IW'(9);
  localparam logic [IW-1:0] M_W  = IW'(17);
  localparam logic [IW-1:0] M_L  = IW'(DATA_W + 1);
  localparam logic [IW-1:0] ONE  = IW'(1);

  function automatic logic bit_at(input logic [XW-1:0] vec, input logic [IW-1:0] idx);
    logic [XW-1:0] t;
    t = vec >> idx;
    return t[0];
  endfunction

  logic [IW-1:0]   w, wp1, n7, nm1, rm, rx, amt;
  logic [WIDE-1:0] wmask, v, sx, asr_r, lsr_r, dbl, ror_r, rol_r, tm, tbits, r;
  logic [XW-1:0]   shl_z, e, rl, m1;
  logic            sgn, zero;

  always_comb begin
    unique case (ctl.size)
      SZ_BYTE: begin w = W_B; rx = IW'(ctl.count) % M_B; end
      SZ_WORD: begin w = W_W; rx = IW'(ctl.count) % M_W; end
      default: begin w = W_L; rx = IW'(ctl.count) % M_L; end
    endcase
    wp1   = w + ONE;
    n7    = IW'(ctl.count);
    nm1   = n7 - ONE;
    zero  = (ctl.count == '0);
    wmask = (WIDE'(1) << w) - WIDE'(1);
    v     = WIDE'(operand) & wmask;
    sgn   = bit_at(XW'(v), w - ONE);
    sx    = sgn ? (v | ~wmask) : v;
    // straight shifts
    asr_r = $unsigned($signed(sx) >>> n7) & wmask;
    lsr_r = v >> n7;
    shl_z = XW'(v) << n7;
    tm    = (((WIDE'(1) << (n7 + ONE)) - WIDE'(1)) << (w - ONE - n7)) & wmask;
    tbits = v & tm;
    // plain rotate over a doubled copy
    dbl   = (v << w) | v;
    rm    = n7 & (w - ONE);
    ror_r = (dbl >> rm) & wmask;
    rol_r = (dbl >> (w - rm)) & wmask;
    // rotate through extend over width+1 bits, expressed as a left rotate
    amt = ctl.left ? rx : ((rx == '0) ? '0 : (wp1 - rx));
    e   = XW'(v) | (XW'(x_in) << w);
    m1  = (XW'(1) << wp1) - XW'(1);
    rl  = ((e << amt) | (e >> (wp1 - amt))) & m1;

    r   = v;
    v_o = 1'b0;
    c_o = 1'b0;
    x_o = x_in;
    unique case (ctl.kind)
      K_ASH, K_LSH: begin
        if (ctl.left) begin
          r   = shl_z[WIDE-1:0] & wmask;
          c_o = !zero && bit_at(shl_z, w);
          if (ctl.kind == K_ASH)
            v_o = (n7 >= w) ? (v != '0) : !((tbits == '0) || (tbits == tm));
        end else begin
          r   = (ctl.kind == K_ASH) ? asr_r : lsr_r;
          c_o = !zero && bit_at(XW'((ctl.kind == K_ASH) ? sx : v), nm1);
        end
        if (!zero) x_o = c_o;
      end
      K_ROX: begin
        r   = rl[WIDE-1:0] & wmask;
        c_o = (rx == '0) ? x_in : bit_at(rl, w);
        x_o = c_o;
      end
      default: begin
        r   = ctl.left ? rol_r : ror_r;
        c_o = !zero && (ctl.left ? r[0] : bit_at(XW'(r), w - ONE));
      end
    endcase
    n_o    = bit_at(XW'(r), w - ONE);
    z_o    = (r == '0);
    result = (operand & ~wmask[DATA_W-1:0]) | r[DATA_W-1:0];
  end

  logic unused_dp;
  assign unused_dp = ^{ctl.mem_form, shl_z, rl, r[WIDE-1:DATA_W], wmask[WIDE-1:DATA_W]};
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [DATA_W-1:0] in_count_reg,
  input  logic              in_x,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_c,
  output logic              out_x,
  output logic [CYC_W-1:0]  out_cycles
);
  shr_ctl_t          ctl;
  logic [CYC_W-1:0]  cyc_d;
  logic [DATA_W-1:0] res_d;
  logic              n_d, z_d, v_d, c_d, x_d;
  logic              fire;

  logic unused_top;
  assign unused_top = ^in_count_reg[DATA_W-1:CNT_W];

  shr_decode u_decode (
    .opcode    (in_opcode),
    .count_src (in_count_reg[CNT_W-1:0]),
    .ctl       (ctl),
    .cycles    (cyc_d)
  );

  shr_datapath u_datapath (
    .ctl     (ctl),
    .operand (in_operand),
    .x_in    (in_x),
    .result  (res_d),
    .n_o     (n_d),
    .z_o     (z_d),
    .v_o     (v_d),
    .c_o     (c_d),
    .x_o     (x_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_n      <= 1'b0;
      out_z      <= 1'b0;
      out_v      <= 1'b0;
      out_c      <= 1'b0;
      out_x      <= 1'b0;
      out_cycles <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_n      <= n_d;
      out_z      <= z_d;
      out_v      <= v_d;
      out_c      <= c_d;
      out_x      <= x_d;
      out_cycles <= cyc_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cycles)); // R10
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R10
  AST_CYCLE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cycles >= CYC_W'(6)); // R9
  AST_ROT_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl.kind == K_ROT |=> out_x == $past(in_x) && !out_v); // R7
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl.size == SZ_BYTE |=> out_result[DATA_W-1:8] == $past(in_operand[DATA_W-1:8])); // R8
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (ctl.kind == K_ASH || ctl.kind == K_LSH) && ctl.count == '0
    |=> !out_c && out_x == $past(in_x)); // R4
  AST_ROX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl.kind == K_ROX && ctl.size == SZ_LONG && ctl.count == CNT_W'(DATA_W + 1)
    |=> out_c == $past(in_x) && out_result == $past(in_operand)); // R6
endmodule

// File: tb/shr_unit_tb.sv
module shr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] tag;
    logic        mem;
    logic [2:0]  ccc;
    logic        left;
    logic [1:0]  ss;
    logic        ireg;
    logic [1:0]  tt;
    logic [31:0] operand;
    logic [31:0] creg;
    logic        x;
    logic [31:0] res;
    logic [4:0]  flags; // N Z V C X
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{"R5  ",1'b0,3'd1,1'b1,2'd0,1'b0,2'd0,32'hAABBCC40,32'h0,1'b0,32'hAABBCC80,5'b10100,8'd8},  // R5 R8 byte ASL 1
    '{"R2  ",1'b0,3'd0,1'b0,2'd1,1'b0,2'd1,32'h12348765,32'h0,1'b1,32'h12340087,5'b00000,8'd22}, // R2 imm 000 = 8
    '{"R2  ",1'b0,3'd3,1'b0,2'd2,1'b1,2'd0,32'h80000018,32'h44,1'b0,32'hF8000001,5'b10011,8'd16}, // R2 reg count mod 64
    '{"R7  ",1'b0,3'd3,1'b0,2'd0,1'b0,2'd3,32'h000000B1,32'h0,1'b1,32'h00000036,5'b00001,8'd12}, // R7 ROR byte
    '{"R7  ",1'b0,3'd0,1'b1,2'd1,1'b1,2'd3,32'hFFFF8001,32'h10,1'b0,32'hFFFF8001,5'b10010,8'd38}, // R7 R8 ROL by width
    '{"R6  ",1'b0,3'd1,1'b1,2'd0,1'b0,2'd2,32'h00000080,32'h0,1'b1,32'h00000001,5'b00011,8'd8},  // R6 ROXL 1
    '{"R6  ",1'b0,3'd0,1'b0,2'd1,1'b1,2'd2,32'h00000000,32'd17,1'b1,32'h00000000,5'b01011,8'd40}, // R6 reduces to 0
    '{"R6  ",1'b0,3'd2,1'b0,2'd2,1'b0,2'd2,32'h00000003,32'h0,1'b0,32'h80000000,5'b10011,8'd12}, // R6 ROXR long 2
    '{"R4  ",1'b0,3'd0,1'b1,2'd0,1'b1,2'd0,32'h000000FF,32'h0,1'b1,32'h000000FF,5'b10001,8'd6},  // R4 zero count
    '{"R5  ",1'b0,3'd0,1'b1,2'd1,1'b0,2'd0,32'h0000FF80,32'h0,1'b0,32'h00008000,5'b10011,8'd22}, // R5 no sign change
    '{"R5  ",1'b0,3'd0,1'b1,2'd0,1'b1,2'd0,32'h00000001,32'd9,1'b0,32'h00000000,5'b01100,8'd24}, // R5 count > width
    '{"R4  ",1'b0,3'd0,1'b0,2'd2,1'b1,2'd1,32'h80000000,32'hE0,1'b1,32'h00000000,5'b01011,8'd72}, // R4 R2 LSR 32
    '{"R3  ",1'b1,3'd0,1'b0,2'd0,1'b0,2'd0,32'h12348001,32'h0,1'b0,32'h1234C000,5'b10011,8'd8},  // R3 R8 mem ASR
    '{"R3  ",1'b1,3'd0,1'b1,2'd0,1'b0,2'd3,32'h00004000,32'h0,1'b1,32'h00008000,5'b10001,8'd8},  // R3 mem ROL
    '{"R4  ",1'b0,3'd0,1'b0,2'd0,1'b0,2'd0,32'h00000080,32'h0,1'b0,32'h000000FF,5'b10011,8'd22}, // R4 ASR byte 8
    '{"R1  ",1'b0,3'd1,1'b1,2'd2,1'b0,2'd1,32'h80000000,32'h0,1'b0,32'h00000000,5'b01011,8'd10}  // R1 LSL long
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_x, out_valid, out_ready;
  logic [15:0] in_opcode;
  logic [31:0] in_operand, in_count_reg, out_result;
  logic        out_n, out_z, out_v, out_c, out_x;
  logic [7:0]  out_cycles;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_operand(in_operand), .in_count_reg(in_count_reg),
    .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c), .out_x(out_x),
    .out_cycles(out_cycles)
  );

  task automatic check(input logic [31:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t t);
    if (t.mem) in_opcode = {4'hE, 1'b0, t.tt, t.left, 2'b11, 6'b010000};
    else       in_opcode = {4'hE, t.ccc, t.left, t.ss, t.ireg, t.tt, 3'b000};
    in_operand   = t.operand;
    in_count_reg = t.creg;
    in_x         = t.x;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_opcode = '0; in_operand = '0; in_count_reg = '0; in_x = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 ", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R11 ", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(VECS[i].tag, "result", out_result, VECS[i].res);
      check(VECS[i].tag, "flags NZVCX", 32'({out_n, out_z, out_v, out_c, out_x}), 32'(VECS[i].flags));
      check("R9  ", "cycles", 32'(out_cycles), 32'(VECS[i].cyc));
    end

    // R10: stall with a held result, a second operation waiting, then drain and accept together
    @(negedge clk);
    out_ready = 1'b0;
    apply(VECS[3]);
    in_valid = 1'b1;
    @(negedge clk);
    apply(VECS[5]);
    check("R10 ", "valid while stalled", 32'(out_valid), 32'd1);
    check("R10 ", "ready low while stalled", 32'(in_ready), 32'd0);
    check("R10 ", "first result", out_result, 32'h00000036);
    repeat (2) @(negedge clk);
    check("R10 ", "held result", out_result, 32'h00000036);
    check("R10 ", "held cycles", 32'(out_cycles), 32'd12);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 ", "swapped result", out_result, 32'h00000001);
    check("R10 ", "valid after swap", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R10 ", "drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule